// File: doc/BRIEF.md
# Delta Quiescent-Current Screening Unit

This unit steps through a stream of test vectors and screens each one on its quiescent supply current. A tester announces each newly applied vector with a one-cycle strobe. The unit then waits a programmable number of clock cycles so that switching transients can die out. After that it accepts one digitized current sample from an external converter. The decision does not use the absolute current. It uses the signed change from the sample of the previous vector. A vector fails when the magnitude of that change is larger than a programmable threshold.

A run begins with a one-cycle start pulse. The start pulse clears all per-run results and latches which supply rail the run measures. The supply choice is held for the whole run. Results come out in several forms:
- a one-cycle comparison strobe with a per-vector fail flag;
- a fail flag that stays set until the next start pulse;
- the index of the first failing vector;
- a sticky protocol-error flag for samples that arrive before settling has finished.

Top module: `deltaIddqScreen`

## Requirements
- R1: After reset, every output is 0 and the unit is idle. While idle, vecApplied and sampleValid have no effect: no comparison strobe is produced and protoErr stays 0.
- R2: A runStart pulse clears stickyFail, firstFailIdx, protoErr, the vector count and the stored previous sample. It starts a new run that waits for a vector strobe.
- R3: If vecApplied is high in cycle c and settleCycles equals S, a sampleValid in cycles c+1 to c+S is rejected. A sampleValid in cycle c+1+S or later is accepted. Only the first accepted sample counts for each vector, and sampleValid with no vector pending is ignored.
- R4: The first accepted sample of a run only seeds the previous-sample register. It produces no comparison strobe and can never fail.
- R5: For every later accepted sample, the difference current minus previous is formed as a 17-bit signed value. The vector fails when the magnitude of the difference is strictly greater than the 16-bit unsigned threshold. A magnitude equal to the threshold passes, and rises and falls are treated alike.
- R6: vecDone and vecFail are pulses that last exactly one cycle. They appear in the cycle after the sample is accepted, and vecFail is high only together with vecDone.
- R7: stickyFail sets on any failing vector and stays set until the next runStart.
- R8: Vector indices count accepted samples from 0 within a run. firstFailIdx captures the index of the first failing vector and is never overwritten by later failures in the same run. A value of 0 means that no vector has failed yet.
- R9: A sampleValid that is rejected because settling is not over sets protoErr in the next cycle, and the sample is discarded. protoErr stays set until runStart.
- R10: A vecApplied strobe that arrives while a measurement is pending discards that measurement and reloads the settling count from the new strobe.
- R11: runSupply takes the value of supplySel at runStart and keeps it for the whole run.
- R12: Every accepted sample, whether it passed or failed, becomes the reference for the next vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| runStart | input | 1 | One-cycle pulse that begins a run |
| supplySel | input | SUPPLY_W | Supply rail under test, latched at runStart |
| vecApplied | input | 1 | Strobe: a new test vector has been applied |
| sampleValid | input | 1 | Converter sample valid |
| sampleData | input | SAMPLE_W | Digitized quiescent current, unsigned |
| threshold | input | SAMPLE_W | Decision threshold on the difference magnitude |
| settleCycles | input | SETTLE_W | Settling wait in clock cycles |
| vecDone | output | 1 | Pulse: a comparison was made |
| vecFail | output | 1 | Pulse: the compared vector failed |
| stickyFail | output | 1 | Some vector of this run failed |
| firstFailIdx | output | IDX_W | Index of the first failing vector |
| protoErr | output | 1 | A sample arrived before settling ended |
| runSupply | output | SUPPLY_W | Supply rail of the current run |

## Verification
The hardest case to reach is a vector strobe that arrives while an earlier measurement is still settling. To show that the counter restarted, the bench times a sample so that it would be late enough for the first strobe but is still early for the second, which must raise protoErr and produce no comparison. The exact settling boundary is tested by sending every normal sample in the first cycle it may be accepted, including a settling count of zero, and by sending an early sample one cycle after the strobe.

// File: rtl/deltaIddqPkg.sv
package deltaIddqPkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WAIT   = 2'd1,
    ST_SETTLE = 2'd2
  } ctrlState_t;

  typedef struct packed {
    logic clear;
    logic capture;
  } ctlStrobes_t;

endpackage

// File: rtl/dqCtrl.sv
module dqCtrl
  import deltaIddqPkg::*;
#(
  parameter int SETTLE_W = 24,
  parameter int SUPPLY_W = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                runStart,
  input  logic [SUPPLY_W-1:0] supplySel,
  input  logic                vecApplied,
  input  logic                sampleValid,
  input  logic [SETTLE_W-1:0] settleCycles,
  output ctlStrobes_t         ctl,
  output logic                protoErr,
  output logic [SUPPLY_W-1:0] runSupply
);

  ctrlState_t          state;
  logic [SETTLE_W-1:0] settleCnt;
  logic                running;
  logic                settled;
  logic                earlySample;

  always_comb begin
    running     = (state != ST_IDLE);
    settled     = (state == ST_SETTLE) && (settleCnt == '0);
    ctl.clear   = runStart;
    ctl.capture = settled && sampleValid && !vecApplied && !runStart;
    earlySample = (state == ST_SETTLE) && (settleCnt != '0) && sampleValid
                  && !vecApplied && !runStart;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      settleCnt <= '0;
      protoErr  <= 1'b0;
      runSupply <= '0;
    end else if (runStart) begin
      state     <= ST_WAIT;
      settleCnt <= '0;
      protoErr  <= 1'b0;
      runSupply <= supplySel;
    end else if (running && vecApplied) begin
      state     <= ST_SETTLE;
      settleCnt <= settleCycles;
    end else if (ctl.capture) begin
      state <= ST_WAIT;
    end else begin
      if (state == ST_SETTLE && settleCnt != '0) settleCnt <= settleCnt - 1'b1;
      if (earlySample) protoErr <= 1'b1;
    end
  end

  // R10: a strobe during a run reloads the settling count
  a_r10_reload: assert property (@(posedge clk) disable iff (!rstN)
    running && vecApplied && !runStart |=>
      (state == ST_SETTLE) && (settleCnt == $past(settleCycles)));

  // R3: the settling count falls by one each cycle while untouched
  a_r3_countdown: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SETTLE) && (settleCnt != '0) && !vecApplied && !runStart |=>
      settleCnt == $past(settleCnt) - 1'b1);

  // R9: an early sample raises the protocol error
  a_r9_early_flag: assert property (@(posedge clk) disable iff (!rstN)
    earlySample |=> protoErr);

  // R11: supply held for the run
  a_r11_supply_hold: assert property (@(posedge clk) disable iff (!rstN)
    !runStart |=> $stable(runSupply));

endmodule

// File: rtl/dqDatapath.sv
module dqDatapath
  import deltaIddqPkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int IDX_W    = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobes_t         ctl,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic [SAMPLE_W-1:0] threshold,
  output logic                vecDone,
  output logic                vecFail,
  output logic                stickyFail,
  output logic [IDX_W-1:0]    firstFailIdx
);

  localparam int DIFF_W = SAMPLE_W + 1;

  logic [SAMPLE_W-1:0]      prevSample;
  logic                     havePrev;
  logic [IDX_W-1:0]         vecIdx;
  logic signed [DIFF_W-1:0] diff;
  logic [DIFF_W-1:0]        diffMag;
  logic                     overLimit;

  always_comb begin
    diff      = $signed({1'b0, sampleData}) - $signed({1'b0, prevSample});
    diffMag   = diff[DIFF_W-1] ? DIFF_W'(-diff) : DIFF_W'(diff);
    overLimit = diffMag > {1'b0, threshold};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevSample   <= '0;
      havePrev     <= 1'b0;
      vecIdx       <= '0;
      vecDone      <= 1'b0;
      vecFail      <= 1'b0;
      stickyFail   <= 1'b0;
      firstFailIdx <= '0;
    end else if (ctl.clear) begin
      prevSample   <= '0;
      havePrev     <= 1'b0;
      vecIdx       <= '0;
      vecDone      <= 1'b0;
      vecFail      <= 1'b0;
      stickyFail   <= 1'b0;
      firstFailIdx <= '0;
    end else begin
      vecDone <= 1'b0;
      vecFail <= 1'b0;
      if (ctl.capture) begin
        prevSample <= sampleData;
        havePrev   <= 1'b1;
        if (vecIdx != '1) vecIdx <= vecIdx + 1'b1;
        if (havePrev) begin
          vecDone <= 1'b1;
          vecFail <= overLimit;
          if (overLimit) begin
            stickyFail <= 1'b1;
            if (!stickyFail) firstFailIdx <= vecIdx;
          end
        end
      end
    end
  end

  // R4: the seeding sample never produces a comparison
  a_r4_seed_silent: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture && !havePrev && !ctl.clear |=> !vecDone);

  // R6: every later capture yields a comparison strobe
  a_r6_done_follows: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture && havePrev && !ctl.clear |=> vecDone);

  // R6: a fail flag never appears without its strobe
  a_r6_fail_with_done: assert property (@(posedge clk) disable iff (!rstN)
    vecFail |-> vecDone);

  // R7, R8: sticky flag and first index hold until cleared
  a_r7_sticky_hold: assert property (@(posedge clk) disable iff (!rstN)
    stickyFail && !ctl.clear |=> stickyFail && $stable(firstFailIdx));

endmodule

// File: rtl/deltaIddqScreen.sv
module deltaIddqScreen
  import deltaIddqPkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int IDX_W    = 16,
  parameter int SETTLE_W = 24,
  parameter int SUPPLY_W = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                runStart,
  input  logic [SUPPLY_W-1:0] supplySel,
  input  logic                vecApplied,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic [SAMPLE_W-1:0] threshold,
  input  logic [SETTLE_W-1:0] settleCycles,
  output logic                vecDone,
  output logic                vecFail,
  output logic                stickyFail,
  output logic [IDX_W-1:0]    firstFailIdx,
  output logic                protoErr,
  output logic [SUPPLY_W-1:0] runSupply
);

  ctlStrobes_t ctl;

  dqCtrl #(.SETTLE_W(SETTLE_W), .SUPPLY_W(SUPPLY_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .runStart(runStart), .supplySel(supplySel),
    .vecApplied(vecApplied), .sampleValid(sampleValid),
    .settleCycles(settleCycles), .ctl(ctl), .protoErr(protoErr),
    .runSupply(runSupply)
  );

  dqDatapath #(.SAMPLE_W(SAMPLE_W), .IDX_W(IDX_W)) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sampleData(sampleData),
    .threshold(threshold), .vecDone(vecDone), .vecFail(vecFail),
    .stickyFail(stickyFail), .firstFailIdx(firstFailIdx)
  );

endmodule

// File: tb/test_deltaIddqScreen.sv
`timescale 1ns/1ps
module test_deltaIddqScreen;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        runStart = 1'b0;
  logic [1:0]  supplySel = '0;
  logic        vecApplied = 1'b0;
  logic        sampleValid = 1'b0;
  logic [15:0] sampleData = '0;
  logic [15:0] threshold = '0;
  logic [23:0] settleCycles = '0;
  logic        vecDone, vecFail, stickyFail, protoErr;
  logic [15:0] firstFailIdx;
  logic [1:0]  runSupply;

  int total = 0;
  int bad = 0;
  bit expQ[$];
  logic [15:0] mPrev;
  bit mHave, mSticky;
  int mIdx, mFirst;
  bit finished = 0;

  always #2.5 clk = ~clk;

  deltaIddqScreen i_deltaIddqScreen (
    .clk(clk), .rstN(rstN), .runStart(runStart), .supplySel(supplySel),
    .vecApplied(vecApplied), .sampleValid(sampleValid), .sampleData(sampleData),
    .threshold(threshold), .settleCycles(settleCycles), .vecDone(vecDone),
    .vecFail(vecFail), .stickyFail(stickyFail), .firstFailIdx(firstFailIdx),
    .protoErr(protoErr), .runSupply(runSupply)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // scoreboard monitor: R5/R6 per-vector results
  always @(negedge clk) begin
    if (rstN && vecDone) begin
      if (expQ.size() == 0) chk(0, "R4/R9 unexpected comparison", 1, 0);
      else begin
        bit e;
        e = expQ.pop_front();
        chk(vecFail == e, "R5 vecFail", vecFail, e);
      end
    end
  end

  task automatic startRun(input logic [1:0] sup, input logic [15:0] thr, input int s);
    @(negedge clk);
    supplySel = sup; threshold = thr; settleCycles = 24'(s); runStart = 1'b1;
    @(negedge clk) runStart = 1'b0;
    mHave = 0; mSticky = 0; mIdx = 0; mFirst = 0;
  endtask

  task automatic modelSample(input logic [15:0] d);
    if (mHave) begin
      int df;
      bit f;
      df = int'(d) - int'(mPrev);
      if (df < 0) df = -df;
      f = (df > int'(threshold));
      expQ.push_back(f);
      if (f && !mSticky) begin mSticky = 1; mFirst = mIdx; end
    end
    mHave = 1; mPrev = d; mIdx++;
  endtask

  task automatic sendSample(input logic [15:0] d);
    modelSample(d);
    sampleValid = 1'b1; sampleData = d;
    @(negedge clk) sampleValid = 1'b0;
    @(negedge clk);
    chk(vecDone == 0 && vecFail == 0, "R6 pulse width", vecDone, 0);
  endtask

  task automatic strobe();
    @(negedge clk) vecApplied = 1'b1;
    @(negedge clk) vecApplied = 1'b0;
  endtask

  task automatic doVec(input logic [15:0] d);
    strobe();
    repeat (int'(settleCycles)) @(negedge clk);
    sendSample(d);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!finished) begin
      chk(0, "watchdog", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(vecDone == 0 && vecFail == 0 && stickyFail == 0 && firstFailIdx == 0 &&
        protoErr == 0 && runSupply == 0, "R1 reset outputs", stickyFail, 0);
    rstN = 1'b1;
    // R1: idle unit ignores strobes and samples
    strobe();
    sampleValid = 1'b1; sampleData = 16'd77;
    @(negedge clk) sampleValid = 1'b0;
    @(negedge clk);
    chk(protoErr == 0 && vecDone == 0, "R1 idle ignore", protoErr, 0);

    // run 1: threshold 100, settle 3, supply 2
    startRun(2'd2, 16'd100, 3);
    chk(runSupply == 2, "R11 supply latch", runSupply, 2);
    supplySel = 2'd0;
    doVec(16'd1000);                    // R4 seed
    doVec(16'd1050);                    // pass
    doVec(16'd1150);                    // R5 equal to threshold passes
    doVec(16'd1049);                    // R5 fall of 101 fails
    chk(stickyFail == 1, "R7 sticky set", stickyFail, 1);
    chk(firstFailIdx == 16'(mFirst), "R8 first index", firstFailIdx, mFirst);
    doVec(16'd1100);                    // R12 diff vs failing sample: 51 passes
    chk(stickyFail == 1, "R7 sticky holds", stickyFail, 1);
    doVec(16'd2000);                    // second failure
    chk(firstFailIdx == 16'(mFirst) && mFirst == 3, "R8 not overwritten", firstFailIdx, 3);
    chk(runSupply == 2, "R11 supply held", runSupply, 2);

    // R9: early sample with settle 4
    settleCycles = 24'd4;
    chk(protoErr == 0, "R9 no error yet", protoErr, 0);
    strobe();
    sampleValid = 1'b1; sampleData = 16'd60000;
    @(negedge clk) sampleValid = 1'b0;
    chk(protoErr == 1, "R9 early flagged", protoErr, 1);
    repeat (3) @(negedge clk);
    sendSample(16'd2050);               // discard of 60000 shows as pass
    chk(protoErr == 1, "R9 sticky error", protoErr, 1);
    // R3: sample with nothing pending ignored
    sampleValid = 1'b1; sampleData = 16'd9;
    @(negedge clk) sampleValid = 1'b0;
    @(negedge clk);

    // run 2: R2 clearing and R10 restart
    startRun(2'd1, 16'd100, 4);
    chk(stickyFail == 0 && firstFailIdx == 0 && protoErr == 0, "R2 run clear",
        stickyFail + protoErr, 0);
    chk(runSupply == 1, "R11 new supply", runSupply, 1);
    doVec(16'd500);                     // R2 seed again, no comparison
    strobe();
    repeat (2) @(negedge clk);
    vecApplied = 1'b1;
    @(negedge clk) vecApplied = 1'b0;
    repeat (2) @(negedge clk);
    sampleValid = 1'b1; sampleData = 16'd500;
    @(negedge clk) sampleValid = 1'b0;
    chk(protoErr == 1, "R10 counter restarted", protoErr, 1);
    repeat (1) @(negedge clk);
    sendSample(16'd700);                // R10 exact boundary of second strobe
    chk(firstFailIdx == 1 && stickyFail == 1, "R8 index after restart", firstFailIdx, 1);

    // run 3: extreme differences, settle 0
    startRun(2'd3, 16'hFFFF, 0);
    doVec(16'hFFFF);
    doVec(16'h0000);                    // R5 magnitude 65535 equal passes
    chk(stickyFail == 0, "R5 max equal pass", stickyFail, 0);
    startRun(2'd3, 16'hFFFE, 0);
    doVec(16'h0000);
    doVec(16'hFFFF);                    // R5 rise of 65535 fails
    chk(stickyFail == 1 && firstFailIdx == 1, "R3 zero settle accepted", firstFailIdx, 1);

    repeat (3) @(negedge clk);
    chk(expQ.size() == 0, "R6 all comparisons seen", expQ.size(), 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule